// File: doc/BRIEF.md
# Quarter-Step Fractional-N Divider Pair

This block divides two clock-rate event streams for a phase-locked synthesizer. A reference divider counts enabled reference ticks and emits one pulse every R ticks. R is a 9-bit ratio. The comparison rate is then four times the wanted channel step. A main divider counts enabled ticks at the oscillator rate. Its modulus is either N or N+1, chosen cycle by cycle by a 2-bit accumulator, so the average ratio is N + k/4. This interpolates the channel step at a quarter of the comparison rate. The main setting is one 15-bit effective word: the upper 13 bits are N and the lower 2 bits are k.

A controller writes both words at once with a load strobe at the end of a bus transfer. Loaded words wait in a holding stage and move into the dividers only on a cycle where the charge pump is not driving current. From reset, both dividers stay idle until the first complete pair of words has been committed. A test enable copies the divided reference and main pulses to two monitor outputs. All counting runs in one clock domain, with per-cycle tick enables for the reference and oscillator streams.

Top module: `qfn_divider_pair`

## Requirements
- R1: After reset, `ref_pulse`, `main_pulse`, `mon_ref` and `mon_main` stay low until a word pair has been loaded and committed, however long the tick enables are high.
- R2: With both enables high and `cp_busy` low, the first `ref_pulse` appears R+2 cycles after the cycle in which `word_load` is sampled high, and the first `main_pulse` N+2 cycles after it. The first main cycle uses modulus N.
- R3: Once running, `ref_pulse` is high for exactly one cycle on every R-th enabled reference tick, with R = `ref_word`.
- R4: A reference word below 36 is treated as 36.
- R5: With N = `main_word[14:2]` and k = `main_word[1:0]`, each main interval is N or N+1 enabled ticks. Any 4 consecutive intervals add up to 4·N+k, so k=0 gives N every time.
- R6: A main word below 2048 is treated as 2048, which gives N=512 and k=0.
- R7: A loaded word pair is committed on the first cycle where `cp_busy` is low. While `cp_busy` stays high, the previous ratios remain in force. A committed ratio is used from the next count boundary on.
- R8: The dividers advance only on cycles where their own enable (`ref_en` or `vco_en`) is high. At half enable rate, the period in clock cycles doubles.
- R9: With `test_en` high, `mon_ref` equals `ref_pulse` and `mon_main` equals `main_pulse`. With `test_en` low, both monitors stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | Reference tick enable |
| vco_en | input | 1 | Oscillator-rate tick enable |
| ref_word | input | 9 | Reference ratio R |
| main_word | input | 15 | Effective main word 4·N+k |
| word_load | input | 1 | Captures both words (end of transfer) |
| cp_busy | input | 1 | Charge pump sourcing or sinking |
| test_en | input | 1 | Routes divided pulses to the monitors |
| ref_pulse | output | 1 | Divided reference pulse to the phase detector |
| main_pulse | output | 1 | Divided main pulse to the phase detector |
| mon_ref | output | 1 | Test monitor of the reference pulse |
| mon_main | output | 1 | Test monitor of the main pulse |

## Verification
A load strobe sampled at one edge is committed at the next edge. The divider counters go live one edge after that, and the first enabled tick is counted on the edge after going live. A first pulse is therefore due R+2 (or N+2) edges after the strobe. The bench samples every output on the falling edge and counts falling edges from the strobe, so each expected latency is an exact number. Period checks count falling edges between consecutive pulses. Those counts match the modulus at full enable rate and twice the modulus at half rate. After a deferred commit, the bench lets two full intervals pass before it measures, because the interval in progress at commit time still uses the old ratio.

// File: rtl/qfn_pkg.sv
package qfn_pkg;

   localparam int unsigned DEF_REF_W    = 9;
   localparam int unsigned DEF_MAIN_W   = 15;
   localparam int unsigned DEF_FRAC_W   = 2;
   localparam int unsigned DEF_REF_MIN  = 36;
   localparam int unsigned DEF_MAIN_MIN = 2048;

   typedef enum logic {
      MOD_BASE = 1'b0,
      MOD_PLUS = 1'b1
   } mod_sel_e;

endpackage

// File: rtl/qfn_word_stage.sv
module qfn_word_stage #(
   parameter int unsigned REF_W    = qfn_pkg::DEF_REF_W,
   parameter int unsigned MAIN_W   = qfn_pkg::DEF_MAIN_W,
   parameter int unsigned REF_MIN  = qfn_pkg::DEF_REF_MIN,
   parameter int unsigned MAIN_MIN = qfn_pkg::DEF_MAIN_MIN,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_load,
   input  logic              cp_busy,
   input  logic [REF_W-1:0]  ref_word,
   input  logic [MAIN_W-1:0] main_word,
   output logic [REF_W-1:0]  act_ref,
   output logic [MAIN_W-1:0] act_main,
   output logic              live
);

   localparam logic [REF_W-1:0]  REF_FLOOR  = REF_W'(REF_MIN);
   localparam logic [MAIN_W-1:0] MAIN_FLOOR = MAIN_W'(MAIN_MIN);

   logic [REF_W-1:0]  ref_in;
   logic [MAIN_W-1:0] main_in;
   logic [REF_W-1:0]  pend_ref;
   logic [MAIN_W-1:0] pend_main;
   logic              pend_vld;
   logic              have_words;
   logic              commit;

   generate
      if (CLAMP_EN) begin : g_clamp
         assign ref_in  = (ref_word  < REF_FLOOR)  ? REF_FLOOR  : ref_word;
         assign main_in = (main_word < MAIN_FLOOR) ? MAIN_FLOOR : main_word;
      end else begin : g_raw
         assign ref_in  = ref_word;
         assign main_in = main_word;
      end
   endgenerate

   assign commit = pend_vld && !cp_busy && !word_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_ref   <= REF_FLOOR;
         pend_main  <= MAIN_FLOOR;
         pend_vld   <= 1'b0;
         act_ref    <= REF_FLOOR;
         act_main   <= MAIN_FLOOR;
         have_words <= 1'b0;
         live       <= 1'b0;
      end else begin
         live <= have_words;
         if (word_load) begin
            pend_ref  <= ref_in;
            pend_main <= main_in;
            pend_vld  <= 1'b1;
         end else if (commit) begin
            act_ref    <= pend_ref;
            act_main   <= pend_main;
            pend_vld   <= 1'b0;
            have_words <= 1'b1;
         end
      end
   end

   assert_commit_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(act_ref) || !$stable(act_main)) |-> !$past(cp_busy));

   assert_live_sticky_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      live |=> live);

endmodule

// File: rtl/qfn_ref_div.sv
module qfn_ref_div #(
   parameter int unsigned REF_W = qfn_pkg::DEF_REF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             live,
   input  logic             tick,
   input  logic [REF_W-1:0] ratio,
   output logic             pulse
);

   localparam logic [REF_W-1:0] ONE = REF_W'(1);

   logic [REF_W-1:0] cnt;
   logic [REF_W-1:0] cur;
   logic             wrap;

   assign wrap = (cnt == cur - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         cur   <= '1;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (!live) begin
            cnt <= '0;
            cur <= ratio;
         end else if (tick) begin
            if (wrap) begin
               cnt   <= '0;
               cur   <= ratio;
               pulse <= 1'b1;
            end else begin
               cnt <= cnt + ONE;
            end
         end
      end
   end

   assert_ref_cnt_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (cnt < cur));

   assert_ref_single_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

endmodule

// File: rtl/qfn_main_div.sv
module qfn_main_div #(
   parameter int unsigned MAIN_W = qfn_pkg::DEF_MAIN_W,
   parameter int unsigned FRAC_W = qfn_pkg::DEF_FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              live,
   input  logic              tick,
   input  logic [MAIN_W-1:0] word,
   output logic              pulse
);

   import qfn_pkg::*;

   localparam int unsigned N_W = MAIN_W - FRAC_W;
   localparam int unsigned M_W = N_W + 1;
   localparam logic [M_W-1:0] ONE = M_W'(1);

   logic [N_W-1:0] n_int;
   logic [M_W-1:0] cnt;
   logic [M_W-1:0] cur;
   logic           wrap;
   mod_sel_e       next_sel;

   assign n_int = word[MAIN_W-1:FRAC_W];
   assign wrap  = (cnt == cur - ONE);

   generate
      if (FRAC_W > 0) begin : g_frac
         logic [FRAC_W-1:0] k_frac;
         logic [FRAC_W-1:0] acc;
         logic [FRAC_W:0]   sum;

         assign k_frac   = word[FRAC_W-1:0];
         assign sum      = {1'b0, acc} + {1'b0, k_frac};
         assign next_sel = sum[FRAC_W] ? MOD_PLUS : MOD_BASE;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc <= '0;
            end else if (!live) begin
               acc <= '0;
            end else if (tick && wrap) begin
               acc <= sum[FRAC_W-1:0];
            end
         end
      end else begin : g_int
         assign next_sel = MOD_BASE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         cur   <= '1;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (!live) begin
            cnt <= '0;
            cur <= {1'b0, n_int};
         end else if (tick) begin
            if (wrap) begin
               cnt   <= '0;
               cur   <= {1'b0, n_int} + ((next_sel == MOD_PLUS) ? ONE : '0);
               pulse <= 1'b1;
            end else begin
               cnt <= cnt + ONE;
            end
         end
      end
   end

   assert_main_cnt_range_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (cnt < cur));

   assert_main_single_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

endmodule

// File: rtl/qfn_divider_pair.sv
module qfn_divider_pair #(
   parameter int unsigned REF_W    = qfn_pkg::DEF_REF_W,
   parameter int unsigned MAIN_W   = qfn_pkg::DEF_MAIN_W,
   parameter int unsigned FRAC_W   = qfn_pkg::DEF_FRAC_W,
   parameter int unsigned REF_MIN  = qfn_pkg::DEF_REF_MIN,
   parameter int unsigned MAIN_MIN = qfn_pkg::DEF_MAIN_MIN,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic              vco_en,
   input  logic [REF_W-1:0]  ref_word,
   input  logic [MAIN_W-1:0] main_word,
   input  logic              word_load,
   input  logic              cp_busy,
   input  logic              test_en,
   output logic              ref_pulse,
   output logic              main_pulse,
   output logic              mon_ref,
   output logic              mon_main
);

   localparam int unsigned N_MIN = MAIN_MIN >> FRAC_W;

   generate
      if (REF_MIN < 2 || REF_MIN >= (1 << REF_W)) begin : g_bad_ref
         $error("qfn_divider_pair: REF_MIN must fit REF_W and be at least 2");
      end
      if (FRAC_W >= MAIN_W) begin : g_bad_frac
         $error("qfn_divider_pair: FRAC_W must be below MAIN_W");
      end
      if (N_MIN < 2 || MAIN_MIN >= (1 << MAIN_W)) begin : g_bad_main
         $error("qfn_divider_pair: MAIN_MIN must fit MAIN_W and give N of at least 2");
      end
   endgenerate

   logic [REF_W-1:0]  act_ref;
   logic [MAIN_W-1:0] act_main;
   logic              live;

   qfn_word_stage #(
      .REF_W    (REF_W),
      .MAIN_W   (MAIN_W),
      .REF_MIN  (REF_MIN),
      .MAIN_MIN (MAIN_MIN),
      .CLAMP_EN (CLAMP_EN)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_load (word_load),
      .cp_busy   (cp_busy),
      .ref_word  (ref_word),
      .main_word (main_word),
      .act_ref   (act_ref),
      .act_main  (act_main),
      .live      (live)
   );

   qfn_ref_div #(
      .REF_W (REF_W)
   ) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .live  (live),
      .tick  (ref_en),
      .ratio (act_ref),
      .pulse (ref_pulse)
   );

   qfn_main_div #(
      .MAIN_W (MAIN_W),
      .FRAC_W (FRAC_W)
   ) u_main (
      .clk   (clk),
      .rst_n (rst_n),
      .live  (live),
      .tick  (vco_en),
      .word  (act_main),
      .pulse (main_pulse)
   );

   assign mon_ref  = test_en & ref_pulse;
   assign mon_main = test_en & main_pulse;

   assert_ref_needs_live_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |-> $past(live));

   assert_main_needs_live_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      main_pulse |-> $past(live));

   assert_ref_needs_tick_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |-> $past(ref_en));

   assert_main_needs_tick_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      main_pulse |-> $past(vco_en));

endmodule

// File: tb/test_qfn_divider_pair.sv
module test_qfn_divider_pair;

   localparam int CLK_PERIOD = 10;
   localparam int WAIT_LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_en = 1'b1;
   logic        vco_en = 1'b1;
   logic [8:0]  ref_word = '0;
   logic [14:0] main_word = '0;
   logic        word_load = 1'b0;
   logic        cp_busy = 1'b0;
   logic        test_en = 1'b0;
   logic        ref_pulse, main_pulse, mon_ref, mon_main;
   logic        half_rate = 1'b0;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   qfn_divider_pair i_qfn_divider_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_en     (ref_en),
      .vco_en     (vco_en),
      .ref_word   (ref_word),
      .main_word  (main_word),
      .word_load  (word_load),
      .cp_busy    (cp_busy),
      .test_en    (test_en),
      .ref_pulse  (ref_pulse),
      .main_pulse (main_pulse),
      .mon_ref    (mon_ref),
      .mon_main   (mon_main)
   );

   initial begin
      forever begin
         @(negedge clk);
         if (half_rate) begin
            ref_en <= ~ref_en;
            vco_en <= ~vco_en;
         end else begin
            ref_en <= 1'b1;
            vco_en <= 1'b1;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      word_load = 1'b0;
      cp_busy = 1'b0;
      test_en = 1'b0;
      half_rate = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic load_words(input int r, input int m);
      @(negedge clk);
      ref_word = 9'(r);
      main_word = 15'(m);
      word_load = 1'b1;
      @(negedge clk);
      word_load = 1'b0;
   endtask

   task automatic wait_pulse(input bit use_main, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(use_main ? main_pulse : ref_pulse) && n < WAIT_LIMIT);
      if (n >= WAIT_LIMIT) begin
         n_checks++;
         n_fail++;
         $display("FAIL wait: actual timeout expected pulse");
      end
   endtask

   task automatic t_reset_hold();
      int seen;
      do_reset();
      check("R1 reset outputs", {ref_pulse, main_pulse, mon_ref, mon_main}, 0);
      test_en = 1'b1;
      seen = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (ref_pulse || main_pulse || mon_ref || mon_main) seen++;
      end
      check("R1 no pulse before words", seen, 0);
      test_en = 1'b0;
   endtask

   task automatic t_first_latency();
      int ref_at, main_at;
      do_reset();
      load_words(40, 2048);
      ref_at = -1;
      main_at = -1;
      for (int i = 1; i <= 600; i++) begin
         @(negedge clk);
         if (ref_pulse && ref_at < 0) ref_at = i;
         if (main_pulse && main_at < 0) main_at = i;
      end
      check("R2 first ref pulse latency", ref_at, 42);
      check("R2 first main pulse latency", main_at, 514);
   endtask

   task automatic t_ref_period();
      int n;
      do_reset();
      load_words(57, 2048);
      wait_pulse(1'b0, n);
      wait_pulse(1'b0, n);
      check("R3 ref period 57", n, 57);
      @(negedge clk);
      check("R3 ref pulse one cycle wide", ref_pulse, 0);
      load_words(200, 2048);
      wait_pulse(1'b0, n);
      wait_pulse(1'b0, n);
      wait_pulse(1'b0, n);
      check("R3 ref period 200", n, 200);
   endtask

   task automatic t_ref_clamp();
      int n;
      do_reset();
      load_words(5, 2048);
      wait_pulse(1'b0, n);
      wait_pulse(1'b0, n);
      check("R4 ref word 5 clamps to 36", n, 36);
   endtask

   task automatic t_main_frac();
      int n, sum, bad;
      do_reset();
      load_words(40, 2400);
      wait_pulse(1'b1, n);
      bad = 0;
      for (int i = 0; i < 4; i++) begin
         wait_pulse(1'b1, n);
         if (n != 600) bad++;
      end
      check("R5 k=0 every interval N", bad, 0);
      do_reset();
      load_words(40, 2403);
      wait_pulse(1'b1, n);
      bad = 0;
      for (int g = 0; g < 2; g++) begin
         sum = 0;
         for (int i = 0; i < 4; i++) begin
            wait_pulse(1'b1, n);
            if (n != 600 && n != 601) bad++;
            sum += n;
         end
         check("R5 k=3 four intervals sum", sum, 2403);
      end
      check("R5 k=3 intervals are N or N+1", bad, 0);
      do_reset();
      load_words(40, 2306);
      wait_pulse(1'b1, n);
      sum = 0;
      for (int i = 0; i < 4; i++) begin
         wait_pulse(1'b1, n);
         sum += n;
      end
      check("R5 k=2 four intervals sum", sum, 2306);
   endtask

   task automatic t_main_clamp();
      int n;
      do_reset();
      load_words(40, 1000);
      wait_pulse(1'b1, n);
      wait_pulse(1'b1, n);
      check("R6 main word 1000 clamps to N 512", n, 512);
   endtask

   task automatic t_cp_defer();
      int n;
      do_reset();
      load_words(40, 2048);
      wait_pulse(1'b0, n);
      @(negedge clk);
      cp_busy = 1'b1;
      load_words(60, 2048);
      repeat (200) @(negedge clk);
      wait_pulse(1'b0, n);
      wait_pulse(1'b0, n);
      check("R7 old ratio kept while busy", n, 40);
      cp_busy = 1'b0;
      wait_pulse(1'b0, n);
      wait_pulse(1'b0, n);
      wait_pulse(1'b0, n);
      check("R7 new ratio after idle", n, 60);
   endtask

   task automatic t_enables();
      int n;
      do_reset();
      load_words(40, 2048);
      wait_pulse(1'b0, n);
      half_rate = 1'b1;
      wait_pulse(1'b0, n);
      wait_pulse(1'b0, n);
      check("R8 ref period at half rate", n, 80);
      wait_pulse(1'b1, n);
      wait_pulse(1'b1, n);
      wait_pulse(1'b1, n);
      check("R8 main period at half rate", n, 1024);
      half_rate = 1'b0;
   endtask

   task automatic t_monitor();
      int mism, hits, refs;
      do_reset();
      load_words(40, 2048);
      test_en = 1'b1;
      mism = 0;
      hits = 0;
      for (int i = 0; i < 1200; i++) begin
         @(negedge clk);
         if (mon_ref != ref_pulse || mon_main != main_pulse) mism++;
         if (mon_ref) hits++;
      end
      check("R9 monitors follow pulses", mism, 0);
      check("R9 monitor activity seen", (hits > 0) ? 1 : 0, 1);
      test_en = 1'b0;
      hits = 0;
      refs = 0;
      for (int i = 0; i < 1200; i++) begin
         @(negedge clk);
         if (mon_ref || mon_main) hits++;
         if (ref_pulse) refs++;
      end
      check("R9 monitors low when disabled", hits, 0);
      check("R9 pulses still present", (refs > 0) ? 1 : 0, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset_hold();
      t_first_latency();
      t_ref_period();
      t_ref_clamp();
      t_main_frac();
      t_main_clamp();
      t_cp_defer();
      t_enables();
      t_monitor();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule